// File: doc/BRIEF.md
# Ethernet Receive Statistics Counters

This block observes a received Ethernet frame stream one byte per beat and keeps two statistics counters that software reads through a small register port. Each beat carries a data byte qualified by a valid strobe, with start-of-frame and end-of-frame markers. The error and drop flags for a frame (CRC error, link error, receive-buffer overrun) are sampled on its end-of-frame beat. While a frame passes, the block captures its destination address, type field and opcode and measures its length. When the frame ends, the block classifies it.

One counter tracks flow-control frames that carry an opcode the receiver does not support. The other tracks good frames that are exactly 64 bytes long, excluding flow-control frames and frames dropped on buffer overrun. Configuration inputs supply the station address, the reserved flow-control multicast address, the flow-control type value and a receive-enable bit. Both counters saturate rather than wrap, and both clear when they are read.

Top module: `rxstat_top`

## Requirements
- R1: The unsupported counter (read select 0) increments once for a frame meeting three conditions. Its destination address (bytes 0 to 5, byte 0 most significant) equals `cfg_fc_mcast` or `cfg_station`. Its type (bytes 12 to 13, big-endian) equals `cfg_fc_type`. Its opcode (bytes 14 to 15, big-endian) is not 0x0001.
- R2: The unsupported counter does not increment for a frame whose end-of-frame beat arrives while `cfg_rx_en` is low.
- R3: A frame shorter than 16 bytes is never treated as a flow-control frame, so it never counts as unsupported.
- R4: The size counter (read select 1) increments for a frame of exactly 64 bytes, counted from the start-of-frame byte through the end-of-frame byte inclusive, whose `rx_crc_err` and `rx_link_err` are both low on the end-of-frame beat. Frames of 63 or 65 bytes do not count.
- R5: The size counter ignores flow-control frames of any opcode. A flow-control frame has at least 16 bytes, a matching address and a matching type. The size counter also ignores frames with `rx_overrun` high on the end-of-frame beat.
- R6: A cycle with `rd_en` high is followed in the next cycle by `rd_valid` high. `rd_data` then holds the selected counter's value from before the read, zero-extended to 32 bits, and the read leaves that counter at zero.
- R7: When a read of a counter and an increment of that counter fall in the same cycle, the read returns the old value and the counter becomes 1.
- R8: A counter at its all-ones value stays there on further increments.
- R9: After reset both counters read zero and `rd_valid` is low.
- R10: Beats with `rx_valid` low add nothing to a frame. Bytes outside a frame are ignored: after an end-of-frame, nothing is taken until the next start-of-frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Byte qualifier |
| rx_sof | input | 1 | First byte of frame |
| rx_eof | input | 1 | Last byte of frame |
| rx_data | input | 8 | Received byte |
| rx_crc_err | input | 1 | CRC error, sampled at end-of-frame |
| rx_link_err | input | 1 | Link error, sampled at end-of-frame |
| rx_overrun | input | 1 | Frame dropped on buffer overrun, sampled at end-of-frame |
| cfg_station | input | 48 | Station address |
| cfg_fc_mcast | input | 48 | Reserved flow-control multicast address |
| cfg_fc_type | input | 16 | Flow-control type value |
| cfg_rx_en | input | 1 | Receive enable |
| rd_en | input | 1 | Read strobe (clears the selected counter) |
| rd_sel | input | 1 | 0 selects the unsupported counter, 1 the 64-byte counter |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |

## Verification
The assertions assume several things about the inputs. Start-of-frame and end-of-frame appear only on valid beats. The configuration is stable from a frame's end-of-frame beat until it has been classified one cycle later. `rd_sel` holds one of the two defined values. The stimulus changes configuration and receive-enable only in idle gaps between frames, and it raises the markers only together with `rx_valid`. Stray bytes are driven only outside frames, to exercise the frame gate. A second instance with narrow counters reaches the saturation value within the run.

// File: rtl/rxstat_pkg.sv
package rxstat_pkg;
    localparam int BYTE_W = 8;
    localparam int MAC_W  = 48;
    localparam int FLD_W  = 16;
    localparam int LEN_W  = 16;
    localparam int RD_W   = 32;
    localparam int NUM_CNT = 2;
    localparam int CNT_UNSUP = 0;
    localparam int CNT_SIZE  = 1;
    localparam int FC_MIN_LEN = 16;
    localparam int SIZE_BIN   = 64;
    localparam logic [FLD_W-1:0] FC_OP_OK = 16'h0001;

    typedef struct packed {
        logic [MAC_W-1:0] da;
        logic [FLD_W-1:0] etype;
        logic [FLD_W-1:0] opcode;
        logic [LEN_W-1:0] len;
        logic             crc_err;
        logic             link_err;
        logic             overrun;
        logic             rx_en;
    } frame_sum_t;
endpackage

// File: rtl/rxstat_parser.sv
module rxstat_parser
    import rxstat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic              rx_sof,
    input  logic              rx_eof,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic              rx_crc_err,
    input  logic              rx_link_err,
    input  logic              rx_overrun,
    input  logic              cfg_rx_en,
    output logic              done,
    output frame_sum_t        sum
);
    localparam logic [LEN_W-1:0] LEN_MAX = '1;

    typedef struct packed {
        logic             in_frame;
        logic [LEN_W-1:0] idx;
        logic [MAC_W-1:0] da;
        logic [FLD_W-1:0] etype;
        logic [FLD_W-1:0] opcode;
        logic             done;
        frame_sum_t       sum;
    } pstate_t;

    pstate_t st_d, st_q;
    logic [LEN_W-1:0] pos_d, len_d;
    logic [MAC_W-1:0] da_w;
    logic [FLD_W-1:0] et_w, op_w;
    logic             take_d;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        pos_d     = rx_sof ? '0 : st_q.idx;
        len_d     = (pos_d == LEN_MAX) ? LEN_MAX : pos_d + 1'b1;
        da_w      = rx_sof ? '0 : st_q.da;
        et_w      = rx_sof ? '0 : st_q.etype;
        op_w      = rx_sof ? '0 : st_q.opcode;
        take_d    = rx_valid && (rx_sof || st_q.in_frame);
        if (pos_d < LEN_W'(6)) begin
            da_w = {da_w[MAC_W-BYTE_W-1:0], rx_data};
        end
        if (pos_d == LEN_W'(12)) et_w[15:8] = rx_data;
        if (pos_d == LEN_W'(13)) et_w[7:0]  = rx_data;
        if (pos_d == LEN_W'(14)) op_w[15:8] = rx_data;
        if (pos_d == LEN_W'(15)) op_w[7:0]  = rx_data;
        if (take_d) begin
            st_d.idx    = len_d;
            st_d.da     = da_w;
            st_d.etype  = et_w;
            st_d.opcode = op_w;
            if (rx_eof) begin
                st_d.in_frame     = 1'b0;
                st_d.done         = 1'b1;
                st_d.sum.da       = da_w;
                st_d.sum.etype    = et_w;
                st_d.sum.opcode   = op_w;
                st_d.sum.len      = len_d;
                st_d.sum.crc_err  = rx_crc_err;
                st_d.sum.link_err = rx_link_err;
                st_d.sum.overrun  = rx_overrun;
                st_d.sum.rx_en    = cfg_rx_en;
            end else begin
                st_d.in_frame = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done = st_q.done;
    assign sum  = st_q.sum;

    // a summary pulse only follows an accepted end-of-frame beat
    AST_DONE_FROM_EOF: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(rx_valid && rx_eof)) else $error("done without eof"); // R10
    // an idle beat leaves the running length untouched
    AST_IDLE_HOLDS_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_valid && st_q.in_frame) |=> st_q.idx == $past(st_q.idx)) else $error("idle beat moved length"); // R10
endmodule

// File: rtl/rxstat_classify.sv
module rxstat_classify
    import rxstat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done,
    input  frame_sum_t        sum,
    input  logic [MAC_W-1:0]  cfg_station,
    input  logic [MAC_W-1:0]  cfg_fc_mcast,
    input  logic [FLD_W-1:0]  cfg_fc_type,
    output logic [NUM_CNT-1:0] inc
);
    logic addr_hit, type_hit, long_enough, fc_frame, good, size_hit;

    always_comb begin
        addr_hit    = (sum.da == cfg_fc_mcast) || (sum.da == cfg_station);
        type_hit    = (sum.etype == cfg_fc_type);
        long_enough = (sum.len >= LEN_W'(FC_MIN_LEN));
        fc_frame    = addr_hit && type_hit && long_enough;
        good        = !sum.crc_err && !sum.link_err;
        size_hit    = (sum.len == LEN_W'(SIZE_BIN));
        inc              = '0;
        inc[CNT_UNSUP]   = done && fc_frame && (sum.opcode != FC_OP_OK) && sum.rx_en;
        inc[CNT_SIZE]    = done && size_hit && good && !sum.overrun && !fc_frame;
    end

    AST_SHORT_NOT_FC: assert property (@(posedge clk) disable iff (!rst_n)
        (done && sum.len < LEN_W'(FC_MIN_LEN)) |-> !inc[CNT_UNSUP]) else $error("short frame as fc"); // R3
    AST_SIZE_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        (done && sum.overrun) |-> !inc[CNT_SIZE]) else $error("overrun frame sized"); // R5
    AST_SIZE_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        inc[CNT_SIZE] |-> (sum.len == LEN_W'(SIZE_BIN))) else $error("size bin wrong length"); // R4
endmodule

// File: rtl/rxstat_counter.sv
module rxstat_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] val;
    } cstate_t;

    cstate_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (clr) begin
            c_d.val = inc ? CNT_W'(1) : '0;
        end else if (inc && (c_q.val != CNT_MAX)) begin
            c_d.val = c_q.val + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign cnt = c_q.val;

    AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.val == CNT_MAX && !clr) |=> c_q.val == CNT_MAX) else $error("counter wrapped"); // R8
    AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> c_q.val <= CNT_W'(1)) else $error("clear left residue"); // R6
    AST_COLLIDE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && inc) |=> c_q.val == CNT_W'(1)) else $error("collision not one"); // R7
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (c_q.val == $past(c_q.val) || c_q.val == $past(c_q.val) + 1'b1)) else $error("bad step"); // R4
endmodule

// File: rtl/rxstat_top.sv
module rxstat_top
    import rxstat_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic              rx_sof,
    input  logic              rx_eof,
    input  logic [7:0]        rx_data,
    input  logic              rx_crc_err,
    input  logic              rx_link_err,
    input  logic              rx_overrun,
    input  logic [47:0]       cfg_station,
    input  logic [47:0]       cfg_fc_mcast,
    input  logic [15:0]       cfg_fc_type,
    input  logic              cfg_rx_en,
    input  logic              rd_en,
    input  logic              rd_sel,
    output logic              rd_valid,
    output logic [31:0]       rd_data
);
    typedef struct packed {
        logic            valid;
        logic [RD_W-1:0] data;
    } rd_t;

    logic                  done_w;
    frame_sum_t            sum_w;
    logic [NUM_CNT-1:0]    inc_w;
    logic [NUM_CNT-1:0]    clr_w;
    logic [CNT_W-1:0]      cnt_w [NUM_CNT];
    rd_t                   rd_d, rd_q;

    rxstat_parser u_parser (
        .clk(clk), .rst_n(rst_n),
        .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_data(rx_data),
        .rx_crc_err(rx_crc_err), .rx_link_err(rx_link_err), .rx_overrun(rx_overrun),
        .cfg_rx_en(cfg_rx_en), .done(done_w), .sum(sum_w)
    );

    rxstat_classify u_classify (
        .clk(clk), .rst_n(rst_n), .done(done_w), .sum(sum_w),
        .cfg_station(cfg_station), .cfg_fc_mcast(cfg_fc_mcast),
        .cfg_fc_type(cfg_fc_type), .inc(inc_w)
    );

    for (genvar gi = 0; gi < NUM_CNT; gi++) begin : g_cnt
        assign clr_w[gi] = rd_en && (rd_sel == 1'(gi));
        rxstat_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk(clk), .rst_n(rst_n), .inc(inc_w[gi]), .clr(clr_w[gi]), .cnt(cnt_w[gi])
        );
    end

    always_comb begin
        rd_d       = rd_q;
        rd_d.valid = rd_en;
        if (rd_en) rd_d.data = RD_W'(cnt_w[rd_sel]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rd_valid = rd_q.valid;
    assign rd_data  = rd_q.data;

    AST_RD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid) else $error("no read response"); // R6
    AST_RD_OLD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !rd_sel) |=> rd_data == RD_W'($past(cnt_w[0]))) else $error("read not old value"); // R6
    AST_UNSUP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (done_w && !sum_w.rx_en && !clr_w[CNT_UNSUP]) |=> cnt_w[CNT_UNSUP] == $past(cnt_w[CNT_UNSUP])) else $error("counted while disabled"); // R2
endmodule

// File: tb/rxstat_top_test.sv
module rxstat_top_test;
    localparam longint BIG_MAX   = 64'hFFFF_FFFF;
    localparam longint SMALL_MAX = 7;
    localparam logic [47:0] MCAST = 48'h0180_C200_0001;
    localparam logic [47:0] STA   = 48'h0012_3456_789A;
    localparam logic [47:0] OTHER = 48'h0A0B_0C0D_0E0F;

    logic clk = 0, rst_n = 0;
    logic rx_valid = 0, rx_sof = 0, rx_eof = 0, rx_crc_err = 0, rx_link_err = 0, rx_overrun = 0;
    logic [7:0] rx_data = 0;
    logic [47:0] cfg_station = STA, cfg_fc_mcast = MCAST;
    logic [15:0] cfg_fc_type = 16'h8808;
    logic cfg_rx_en = 1;
    logic rd_en = 0, rd_sel = 0;
    logic rd_valid, rd_valid_s;
    logic [31:0] rd_data, rd_data_s;

    always #5 clk = ~clk;

    rxstat_top #(.CNT_W(32)) uut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof),
        .rx_data(rx_data), .rx_crc_err(rx_crc_err), .rx_link_err(rx_link_err),
        .rx_overrun(rx_overrun), .cfg_station(cfg_station), .cfg_fc_mcast(cfg_fc_mcast),
        .cfg_fc_type(cfg_fc_type), .cfg_rx_en(cfg_rx_en), .rd_en(rd_en), .rd_sel(rd_sel),
        .rd_valid(rd_valid), .rd_data(rd_data));

    rxstat_top #(.CNT_W(3)) uut_small (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof),
        .rx_data(rx_data), .rx_crc_err(rx_crc_err), .rx_link_err(rx_link_err),
        .rx_overrun(rx_overrun), .cfg_station(cfg_station), .cfg_fc_mcast(cfg_fc_mcast),
        .cfg_fc_type(cfg_fc_type), .cfg_rx_en(cfg_rx_en), .rd_en(rd_en), .rd_sel(rd_sel),
        .rd_valid(rd_valid_s), .rd_data(rd_data_s));

    int n_cmp = 0, n_bad = 0;
    string cur_req = "R9";

    // behavioural reference model
    byte unsigned fq[$];
    bit      in_frame = 0;
    longint  m_big[2], m_small[2];
    bit      pend[2];
    bit      exp_valid = 0;
    longint  exp_big = 0, exp_small = 0;

    function automatic void classify(output bit u, output bit s);
        int len = fq.size();
        bit [47:0] da = 0;
        bit [15:0] ty = 0, op = 0;
        bit fc;
        if (len >= 16) begin
            for (int i = 0; i < 6; i++) da = {da[39:0], fq[i]};
            ty = {fq[12], fq[13]};
            op = {fq[14], fq[15]};
        end
        fc = (len >= 16) && (da == cfg_fc_mcast || da == cfg_station) && (ty == cfg_fc_type);
        u  = fc && (op != 16'h0001) && cfg_rx_en;
        s  = (len == 64) && !rx_crc_err && !rx_link_err && !rx_overrun && !fc;
    endfunction

    bit eof_seen = 0, u_n = 0, s_n = 0;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_big = '{0, 0}; m_small = '{0, 0}; pend = '{0, 0};
            exp_valid = 0; in_frame = 0; fq.delete();
        end else begin
            // classify frame ending this edge (uses config of this cycle; held stable)
            eof_seen = 0;
            if (rx_valid && (rx_sof || in_frame)) begin
                if (rx_sof) fq.delete();
                fq.push_back(rx_data);
                if (rx_eof) begin
                    classify(u_n, s_n);
                    eof_seen = 1;
                    in_frame = 0;
                end else in_frame = 1;
            end
            exp_valid = rd_en;
            if (rd_en) begin
                exp_big   = m_big[rd_sel];
                exp_small = m_small[rd_sel];
            end
            for (int i = 0; i < 2; i++) begin
                if (rd_en && rd_sel == i[0]) begin
                    m_big[i]   = pend[i] ? 1 : 0;
                    m_small[i] = pend[i] ? 1 : 0;
                end else if (pend[i]) begin
                    if (m_big[i] < BIG_MAX) m_big[i]++;
                    if (m_small[i] < SMALL_MAX) m_small[i]++;
                end
            end
            pend[0] = eof_seen && u_n;
            pend[1] = eof_seen && s_n;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (rd_valid !== exp_valid || rd_valid_s !== exp_valid) begin
                n_cmp++; n_bad++;
                $display("FAIL %s rd_valid actual %0b/%0b expected %0b", cur_req, rd_valid, rd_valid_s, exp_valid);
            end else if (exp_valid) begin
                n_cmp++;
                if (rd_data !== exp_big[31:0] || rd_data_s !== exp_small[31:0]) begin
                    n_bad++;
                    $display("FAIL %s rd_data actual %0d/%0d expected %0d/%0d",
                             cur_req, rd_data, rd_data_s, exp_big, exp_small);
                end
            end
        end
    end

    task automatic idle(int n);
        repeat (n) begin
            @(negedge clk);
            rx_valid = 0; rx_sof = 0; rx_eof = 0; rd_en = 0;
        end
    endtask

    task automatic send(int len, logic [47:0] da, logic [15:0] ty, logic [15:0] op,
                        bit crc = 0, bit lnk = 0, bit ovr = 0, bit gaps = 0);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            rd_en = 0;
            rx_valid = 1; rx_sof = (i == 0); rx_eof = (i == len - 1);
            rx_crc_err = crc; rx_link_err = lnk; rx_overrun = ovr;
            if (i < 6)       rx_data = da[47 - 8*i -: 8];
            else if (i == 12) rx_data = ty[15:8];
            else if (i == 13) rx_data = ty[7:0];
            else if (i == 14) rx_data = op[15:8];
            else if (i == 15) rx_data = op[7:0];
            else             rx_data = 8'(i + 8'h30);
            if (gaps && i != len - 1) begin
                @(negedge clk);
                rx_valid = 0; rx_sof = 0; rx_eof = 0;
            end
        end
    endtask

    task automatic rd(bit sel);
        @(negedge clk);
        rx_valid = 0; rx_sof = 0; rx_eof = 0;
        rd_en = 1; rd_sel = sel;
        idle(2);
    endtask

    task automatic settle_read_both();
        idle(3); rd(0); rd(1);
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog expired in %s", cur_req);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        idle(3);
        @(negedge clk); rst_n = 1;
        cur_req = "R9"; rd(0); rd(1);

        cur_req = "R4"; send(64, OTHER, 16'h0800, 16'h1234); settle_read_both();
        send(63, OTHER, 16'h0800, 16'h0); idle(1); send(65, OTHER, 16'h0800, 16'h0); settle_read_both();
        send(64, OTHER, 16'h0800, 16'h0, 1, 0, 0); idle(1);
        send(64, OTHER, 16'h0800, 16'h0, 0, 1, 0); settle_read_both();

        cur_req = "R5"; send(64, OTHER, 16'h0800, 16'h0, 0, 0, 1); idle(1);
        send(64, MCAST, 16'h8808, 16'h0001); idle(1);
        send(64, STA, 16'h8808, 16'h0009); settle_read_both();

        cur_req = "R1"; send(60, MCAST, 16'h8808, 16'h0002); settle_read_both();
        send(20, STA, 16'h8808, 16'h0000); idle(1);
        send(20, OTHER, 16'h8808, 16'h0002); idle(1);
        send(20, MCAST, 16'h8809, 16'h0002); idle(1);
        send(20, MCAST, 16'h8808, 16'h0001); settle_read_both();

        cur_req = "R2"; idle(1); cfg_rx_en = 0;
        send(30, MCAST, 16'h8808, 16'h0005); idle(2); cfg_rx_en = 1; settle_read_both();

        cur_req = "R3"; send(15, MCAST, 16'h8808, 16'h0002); settle_read_both();
        send(16, MCAST, 16'h8808, 16'h0002); settle_read_both();

        cur_req = "R10"; send(64, OTHER, 16'h0800, 16'h0, 0, 0, 0, 1); settle_read_both();
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); rx_valid = 1; rx_sof = 0; rx_eof = (i == 2); rx_data = 8'h55;
        end
        send(64, OTHER, 16'h0800, 16'h0); settle_read_both();

        cur_req = "R6"; send(64, OTHER, 16'h0800, 16'h0); idle(3); rd(1); rd(1);

        cur_req = "R7"; send(64, OTHER, 16'h0800, 16'h0); idle(3);
        send(64, OTHER, 16'h0800, 16'h0);
        rd(1); rd(1);

        cur_req = "R8";
        for (int k = 0; k < 9; k++) begin send(64, OTHER, 16'h0800, 16'h0); idle(1); end
        settle_read_both();

        idle(4);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule